// File: doc/BRIEF.md
# Storage Adapter Global Control Register

This block is the 32-bit global control word of a storage host bus adapter, located at byte offset 4 of the adapter's register space and reached through a simple read/write strobe port with per-byte enables. It holds three pieces of state.

The first is a mode bit that says the adapter is driven through its native command interface. A strap input decides whether that bit is fixed at 1 or is writable by software. The second is a global interrupt enable that gates the adapter's interrupt request. The third is a software-triggered adapter reset. Writing 1 sets it, and it clears itself once the port logic reports that the reset has finished.

The block also derives, without storing anything, a status bit that reports when the adapter has fallen back from multi-vector MSI to a single vector. It drives a vector-select output that forces vector 0 whenever fewer vectors were granted than were asked for. The MSI capability fields arrive as inputs, and the port state machines sit behind the reset request and done handshake.

Top module: `hba_global_ctrl`

## Requirements
- R1: After reset, a read of offset 4 returns bit 1 = 0, bit 0 = 0, bits 30:3 = 0, and bit 31 equal to the strap input `strap_native_only`.
- R2: With `strap_native_only` = 1, bit 31 always reads 1, and writing 0 to it has no effect.
- R3: With `strap_native_only` = 0, bit 31 resets to 0 and is readable and writable through byte lane 3.
- R4: Bits 30:3 always read 0, even after a write of all ones.
- R5: Bit 1 is a readable and writable interrupt enable. `irq_req` equals bit 1 ANDed with the OR of all `port_irq_pend` bits, so it is low whenever bit 1 is 0.
- R6: A write with bit 0 = 1 (byte lane 0 enabled) sets bit 0. From the next cycle, `adapter_rst_req` is high. A write with bit 0 = 0 leaves bit 0 unchanged.
- R7: A one-cycle `adapter_rst_done` pulse clears bit 0 and `adapter_rst_req` on the following cycle, unless the same cycle also writes 1 to bit 0. Without the pulse the bit holds, and after clearing it can be set again.
- R8: Bit 2 reads 1 and `msi_revert` is 1 exactly when all four of these hold: `msi_enable` = 1, `msi_req_log2` > 0, `msi_alloc_log2` > 0, and `msi_alloc_log2` ≠ `msi_req_log2`. It is computed from the live input values.
- R9: When `msi_enable` = 1 and `msi_alloc_log2` = 0, bit 2 and `msi_revert` read 0.
- R10: `msi_vec0_only` is 1 exactly when `msi_alloc_log2` < `msi_req_log2`, with both compared as unsigned 3-bit log2 encodings.
- R11: A write updates only bits whose byte lane is enabled in `reg_be` (bit n of `reg_be` covers data bits 8n+7:8n). A write to any offset other than 4 changes nothing.
- R12: `reg_rdata` shows the register in the same cycle that `reg_rd` is high with `reg_addr` = 4. At any other time it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_native_only | input | 1 | 1: mode bit fixed at 1; 0: mode bit writable |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_be | input | 4 | Byte-lane enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| port_irq_pend | input | NUM_PORTS | Pending interrupt per port |
| irq_req | output | 1 | Gated interrupt request |
| adapter_rst_req | output | 1 | Reset request to the port state machines |
| adapter_rst_done | input | 1 | One-cycle pulse: reset action complete |
| msi_enable | input | 1 | MSI enabled, from the capability |
| msi_req_log2 | input | MSI_W | log2 of the number of vectors requested |
| msi_alloc_log2 | input | MSI_W | log2 of the number of vectors allocated |
| msi_revert | output | 1 | Single-vector reversion status |
| msi_vec0_only | output | 1 | Force use of vector 0 |

## Verification
The MSI status is driven with allocations below, equal to and above the request. These cases separate the revert bit, which is set on any mismatch, from the vector-0 force, which applies only to a shortfall. A zero allocation under an enabled MSI, a zero request, and a disabled MSI each show that a single one of the four conditions is enough to clear the status. The reset bit is driven with a set, a hold without a done pulse, a done pulse, a write of 0, and a done pulse that coincides with a new write of 1. Writes with partial byte enables and writes to other offsets separate lane masking from address decoding.

// File: rtl/hba_gc_pkg.sv
package hba_gc_pkg;
    localparam int DATA_W     = 32;
    localparam int BE_W       = DATA_W / 8;
    localparam int MODE_BIT   = 31;
    localparam int REVERT_BIT = 2;
    localparam int IEN_BIT    = 1;
    localparam int ARST_BIT   = 0;

    typedef struct packed {
        logic mode;
        logic ien;
        logic arst;
    } gc_state_t;

    localparam gc_state_t GC_RESET = '{mode: 1'b0, ien: 1'b0, arst: 1'b0};
endpackage

// File: rtl/hba_gc_lane_mask.sv
module hba_gc_lane_mask
    import hba_gc_pkg::*;
(
    input  logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] mask
);
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign mask[g*8 +: 8] = {8{be[g]}};
    end
endmodule

// File: rtl/hba_gc_msi_eval.sv
module hba_gc_msi_eval #(
    parameter int MSI_W = 3
) (
    input  logic             enable,
    input  logic [MSI_W-1:0] req_log2,
    input  logic [MSI_W-1:0] alloc_log2,
    output logic             revert,
    output logic             vec0_only
);
    logic req_multi;
    logic alloc_multi;
    logic mismatch;

    always_comb begin
        req_multi   = |req_log2;
        alloc_multi = |alloc_log2;
        mismatch    = (alloc_log2 != req_log2);
        revert      = enable & req_multi & alloc_multi & mismatch;
        vec0_only   = (alloc_log2 < req_log2);
    end
endmodule

// File: rtl/hba_gc_irq_gate.sv
module hba_gc_irq_gate #(
    parameter int NUM_PORTS = 8
) (
    input  logic                 ien,
    input  logic [NUM_PORTS-1:0] pend,
    output logic                 irq
);
    logic [NUM_PORTS:0] chain;

    assign chain[0] = 1'b0;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_or
        assign chain[p+1] = chain[p] | pend[p];
    end

    assign irq = ien & chain[NUM_PORTS];
endmodule

// File: rtl/hba_global_ctrl.sv
module hba_global_ctrl
    import hba_gc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int REG_OFS   = 4,
    parameter int NUM_PORTS = 8,
    parameter int MSI_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strap_native_only,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [3:0]           reg_be,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_PORTS-1:0] port_irq_pend,
    output logic                 irq_req,
    output logic                 adapter_rst_req,
    input  logic                 adapter_rst_done,
    input  logic                 msi_enable,
    input  logic [MSI_W-1:0]     msi_req_log2,
    input  logic [MSI_W-1:0]     msi_alloc_log2,
    output logic                 msi_revert,
    output logic                 msi_vec0_only
);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);

    gc_state_t        st_d, st_q;
    logic             hit;
    logic             wr_hit;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] wr_bits;
    logic [DATA_W-1:0] wr_sel;
    logic             ien_bit;

    hba_gc_lane_mask u_mask (
        .be   (reg_be),
        .mask (lane_mask)
    );

    hba_gc_msi_eval #(.MSI_W(MSI_W)) u_msi (
        .enable     (msi_enable),
        .req_log2   (msi_req_log2),
        .alloc_log2 (msi_alloc_log2),
        .revert     (msi_revert),
        .vec0_only  (msi_vec0_only)
    );

    hba_gc_irq_gate #(.NUM_PORTS(NUM_PORTS)) u_irq (
        .ien  (st_q.ien),
        .pend (port_irq_pend),
        .irq  (irq_req)
    );

    // Next-state computation for the three stored bits.
    always_comb begin
        hit     = (reg_addr == OFS);
        wr_hit  = reg_wr & hit;
        wr_sel  = wr_hit ? lane_mask : '0;
        wr_bits = reg_wdata & wr_sel;
        st_d    = st_q;

        if (!strap_native_only && wr_sel[MODE_BIT]) begin
            st_d.mode = reg_wdata[MODE_BIT];
        end
        if (wr_sel[IEN_BIT]) begin
            st_d.ien = reg_wdata[IEN_BIT];
        end
        // A new write of 1 wins over a completion in the same cycle.
        if (wr_bits[ARST_BIT]) begin
            st_d.arst = 1'b1;
        end else if (adapter_rst_done) begin
            st_d.arst = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= GC_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    // Read path: live view of the stored bits and the derived status.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd && hit) begin
            reg_rdata[MODE_BIT]   = strap_native_only | st_q.mode;
            reg_rdata[REVERT_BIT] = msi_revert;
            reg_rdata[IEN_BIT]    = st_q.ien;
            reg_rdata[ARST_BIT]   = st_q.arst;
        end
    end

    assign adapter_rst_req = st_q.arst;
    assign ien_bit         = st_q.ien;
endmodule

// File: rtl/hba_global_ctrl_chk.sv
module hba_global_ctrl_chk #(
    parameter int ADDR_W    = 8,
    parameter int REG_OFS   = 4,
    parameter int MSI_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strap_native_only,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [3:0]        reg_be,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              irq_req,
    input logic              ien_bit,
    input logic              adapter_rst_req,
    input logic              adapter_rst_done,
    input logic              msi_enable,
    input logic [MSI_W-1:0]  msi_req_log2,
    input logic [MSI_W-1:0]  msi_alloc_log2,
    input logic              msi_revert,
    input logic              msi_vec0_only
);
    logic set_wr;
    assign set_wr = reg_wr && (reg_addr == ADDR_W'(REG_OFS)) && reg_be[0] && reg_wdata[0];

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_bit |-> !irq_req); // R5
    AST_RST_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> adapter_rst_req); // R6
    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (adapter_rst_done && !set_wr) |=> !adapter_rst_req); // R7
    AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (adapter_rst_req && !adapter_rst_done) |=> adapter_rst_req); // R7
    AST_ALLOC0_NO_REVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_enable && msi_alloc_log2 == '0) |-> !msi_revert); // R9
    AST_SHORTFALL_VEC0: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_alloc_log2 < msi_req_log2) |-> msi_vec0_only); // R10
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[30:3] == '0); // R4
    AST_MODE_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_native_only && reg_rd && reg_addr == ADDR_W'(REG_OFS)) |-> reg_rdata[31]); // R2
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> (reg_rdata == '0)); // R12
endmodule

bind hba_global_ctrl hba_global_ctrl_chk #(
    .ADDR_W(ADDR_W), .REG_OFS(REG_OFS), .MSI_W(MSI_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .strap_native_only(strap_native_only),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .ien_bit(ien_bit), .adapter_rst_req(adapter_rst_req),
    .adapter_rst_done(adapter_rst_done), .msi_enable(msi_enable),
    .msi_req_log2(msi_req_log2), .msi_alloc_log2(msi_alloc_log2),
    .msi_revert(msi_revert), .msi_vec0_only(msi_vec0_only)
);

// File: tb/sim_hba_global_ctrl.sv
`timescale 1ns/1ps
module sim_hba_global_ctrl;
    localparam int NP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NP-1:0] pend = '0;
    logic        irq, rreq, rdone = 1'b0;
    logic        men = 1'b0;
    logic [2:0]  mreq = '0, malloc = '0;
    logic        mrev, mvec0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hba_global_ctrl #(.ADDR_W(8), .REG_OFS(4), .NUM_PORTS(NP), .MSI_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .strap_native_only(strap),
        .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_be(be),
        .reg_wdata(wdata), .reg_rdata(rdata), .port_irq_pend(pend),
        .irq_req(irq), .adapter_rst_req(rreq), .adapter_rst_done(rdone),
        .msi_enable(men), .msi_req_log2(mreq), .msi_alloc_log2(malloc),
        .msi_revert(mrev), .msi_vec0_only(mvec0)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        strap = s; rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; be = b; wdata = d;
        @(negedge clk);
        wr = 1'b0; be = '0; wdata = '0; addr = '0;
    endtask

    task automatic do_read(output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = 8'd4;
        #0.5 d = rdata;
        rd = 1'b0; addr = '0;
    endtask

    task automatic t_reset_state;
        logic [31:0] d;
        do_reset(1'b0);
        do_read(d);
        chk("R1 reset strap0", d, 32'h0000_0000);
        chk("R12 idle rdata zero", rdata, 32'h0);
        do_reset(1'b1);
        do_read(d);
        chk("R1 reset strap1", d, 32'h8000_0000);
        chk("R5 irq low after reset", {31'b0, irq}, 32'h0);
        chk("R6 rst_req low after reset", {31'b0, rreq}, 32'h0);
    endtask

    task automatic t_mode_bit;
        logic [31:0] d;
        do_reset(1'b1);
        do_write(8'd4, 4'hF, 32'h0000_0000);
        do_read(d);
        chk("R2 mode fixed at 1", d, 32'h8000_0000);
        do_reset(1'b0);
        do_write(8'd4, 4'h8, 32'h8000_0000);
        do_read(d);
        chk("R3 mode written 1", d, 32'h8000_0000);
        do_write(8'd4, 4'h8, 32'h0000_0000);
        do_read(d);
        chk("R3 mode written 0", d, 32'h0);
    endtask

    task automatic t_reserved;
        logic [31:0] d;
        do_reset(1'b0);
        do_write(8'd4, 4'hF, 32'hFFFF_FFFE);
        do_read(d);
        chk("R4 reserved read zero", d, 32'h8000_0002);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        do_reset(1'b0);
        @(negedge clk); pend = 8'h10; #0.5;
        chk("R5 irq masked while disabled", {31'b0, irq}, 32'h0);
        do_write(8'd4, 4'h1, 32'h0000_0002);
        #0.5 chk("R5 irq with enable", {31'b0, irq}, 32'h1);
        do_read(d);
        chk("R5 enable readback", d, 32'h0000_0002);
        @(negedge clk); pend = 8'h00; #0.5;
        chk("R5 irq low without pending", {31'b0, irq}, 32'h0);
        @(negedge clk); pend = 8'h81;
        do_write(8'd4, 4'h1, 32'h0000_0000);
        #0.5 chk("R5 irq off after disable", {31'b0, irq}, 32'h0);
        pend = '0;
    endtask

    task automatic t_adapter_reset;
        logic [31:0] d;
        do_reset(1'b0);
        do_write(8'd4, 4'h1, 32'h0000_0001);
        #0.5 chk("R6 rst_req after set", {31'b0, rreq}, 32'h1);
        do_write(8'd4, 4'h1, 32'h0000_0000);
        do_read(d);
        chk("R6 write 0 no effect", d, 32'h0000_0001);
        repeat (3) @(negedge clk);
        chk("R7 holds without done", {31'b0, rreq}, 32'h1);
        @(negedge clk); rdone = 1'b1;
        @(negedge clk); rdone = 1'b0;
        #0.5 chk("R7 cleared after done", {31'b0, rreq}, 32'h0);
        do_read(d);
        chk("R7 bit reads 0", d, 32'h0);
        do_write(8'd4, 4'h1, 32'h0000_0001);
        #0.5 chk("R7 settable again", {31'b0, rreq}, 32'h1);
        @(negedge clk);
        wr = 1'b1; addr = 8'd4; be = 4'h1; wdata = 32'h1; rdone = 1'b1;
        @(negedge clk);
        wr = 1'b0; be = '0; wdata = '0; addr = '0; rdone = 1'b0;
        #0.5 chk("R7 write beats done", {31'b0, rreq}, 32'h1);
        @(negedge clk); rdone = 1'b1;
        @(negedge clk); rdone = 1'b0;
        #0.5 chk("R7 final clear", {31'b0, rreq}, 32'h0);
    endtask

    task automatic msi_case(input logic e, input logic [2:0] rq, input logic [2:0] al,
                            input logic exp_rev, input logic exp_v0, input string tag);
        logic [31:0] d;
        @(negedge clk);
        men = e; mreq = rq; malloc = al;
        do_read(d);
        chk({tag, " revert"}, {31'b0, mrev}, {31'b0, exp_rev});
        chk({tag, " status bit"}, {29'b0, d[2], 2'b0}, {29'b0, exp_rev, 2'b0});
        chk("R10 vec0 select", {31'b0, mvec0}, {31'b0, exp_v0});
    endtask

    task automatic t_msi;
        do_reset(1'b0);
        msi_case(1'b1, 3'd3, 3'd1, 1'b1, 1'b1, "R8 shortfall");
        msi_case(1'b1, 3'd1, 3'd3, 1'b1, 1'b0, "R8 excess");
        msi_case(1'b1, 3'd2, 3'd2, 1'b0, 1'b0, "R8 equal");
        msi_case(1'b0, 3'd3, 3'd1, 1'b0, 1'b1, "R8 disabled");
        msi_case(1'b1, 3'd0, 3'd0, 1'b0, 1'b0, "R8 single request");
        msi_case(1'b1, 3'd2, 3'd0, 1'b0, 1'b1, "R9 alloc zero");
        msi_case(1'b1, 3'd5, 3'd4, 1'b1, 1'b1, "R8 high codes");
        @(negedge clk); men = 1'b0; mreq = '0; malloc = '0;
    endtask

    task automatic t_byte_en;
        logic [31:0] d;
        do_reset(1'b0);
        do_write(8'd4, 4'h6, 32'hFFFF_FFFF);
        do_read(d);
        chk("R11 disabled lanes ignored", d, 32'h0);
        do_write(8'd4, 4'h8, 32'hFFFF_FFFF);
        do_read(d);
        chk("R11 lane 3 only", d, 32'h8000_0000);
        do_write(8'd0, 4'hF, 32'h0000_0003);
        do_write(8'd8, 4'hF, 32'h0000_0003);
        do_read(d);
        chk("R11 other offsets ignored", d, 32'h8000_0000);
        chk("R6 no reset from other offset", {31'b0, rreq}, 32'h0);
    endtask

    task automatic t_read_path;
        do_reset(1'b1);
        do_write(8'd4, 4'h1, 32'h0000_0002);
        @(negedge clk);
        rd = 1'b1; addr = 8'd0; #0.5;
        chk("R12 other offset read zero", rdata, 32'h0);
        addr = 8'd4; #0.5;
        chk("R12 same-cycle read", rdata, 32'h8000_0002);
        men = 1'b1; mreq = 3'd2; malloc = 3'd1; #0.5;
        chk("R12 live status in read", rdata, 32'h8000_0006);
        rd = 1'b0; addr = '0; men = 1'b0; mreq = '0; malloc = '0;
    endtask

    initial begin
        t_reset_state();
        t_mode_bit();
        t_reserved();
        t_irq();
        t_adapter_reset();
        t_msi();
        t_byte_en();
        t_read_path();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule